// File: doc/BRIEF.md
# Memory-IO Bus Interface Logic

This block sits between a processor controller and its memory-IO bus. The controller raises a single access enable together with a read/write select, and presents the address and the write data. The block splits that request into separate bus read and bus write strobes. It decodes whether the address falls in the memory window and lets a strobe through to the memory only when it does. The data returned toward the controller is forced to zero whenever no memory read is in progress.

A behavioural memory of 16-bit words is built in. It answers each request after a fixed number of clock cycles, set by a parameter, and it indexes its storage with the low address bits, so a small array aliases across the window. IO devices outside the block are represented only by their ready lines. The memory's ready and every IO ready are ORed into the single ready returned to the controller. The controller holds its request until ready is high, then drops it.

Top module: `mio_bus_ctrl`

## Requirements
- R1: `bus_rd` equals `mio_en` AND NOT `rw`, and `bus_wr` equals `mio_en` AND `rw`, where `rw`=1 means write. The two strobes are never high together.
- R2: `mem_sel` is 1 exactly when `addr` is below `MEM_LIMIT` (default 16'hFE00). Addresses at or above the limit belong to IO.
- R3: `mem_rd` equals `bus_rd` AND `mem_sel`, and `mem_wr` equals `bus_wr` AND `mem_sel`.
- R4: `rd_data` shows the stored word at index `addr[MEM_AW-1:0]` while `mem_rd` is 1, and is 16'h0000 otherwise.
- R5: Once a memory request (`mem_rd` or `mem_wr`) has been held for `LAT` rising edges, the memory ready goes high. It stays high while the request is held, and it falls in the same cycle that the request drops.
- R6: `ready` is the OR of the memory ready and every bit of `io_ready`.
- R7: On the rising edge where `mem_wr` and the memory ready are both high, `wr_data` is stored at index `addr[MEM_AW-1:0]`. Addresses that differ only above bit `MEM_AW-1` reach the same word.
- R8: After reset every word reads 16'h0000, and `ready` is 0 while no request is made and `io_ready` is 0.
- R9: A write to an address at or above `MEM_LIMIT` leaves every memory word unchanged, and it gets no memory ready.
- R10: A write request withdrawn before the memory ready rises leaves the addressed word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mio_en | input | 1 | Controller wants a memory-IO access |
| rw | input | 1 | 0 = read, 1 = write |
| addr | input | 16 | Address bus, driven by the controller's address register |
| wr_data | input | 16 | Write data from the controller's data register |
| io_ready | input | N_IO | Ready lines of the IO devices |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| mem_sel | output | 1 | Address lies in the memory window |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| rd_data | output | 16 | Data bus toward the controller's data register |
| ready | output | 1 | Combined ready returned to the controller |

## Verification
The hardest cases to reach are the ones where storage must not change: a write to an IO address that aliases onto a memory word, and a write withdrawn one edge before the memory ready rises. Neither case changes any output while it happens. The bench therefore follows each with a read of the word that could have been hit and compares it against its own model. The ready timing is probed edge by edge around the latency boundary. The decode is swept across the whole address space in steps, with extra probes on each side of the limit.

// File: rtl/mio_pkg.sv
package mio_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 16;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/mio_strobe_gen.sv
module mio_strobe_gen (
  input  logic mio_en,
  input  logic rw,
  output logic bus_rd,
  output logic bus_wr
);
  always_comb begin
    bus_rd = mio_en & ~rw;
    bus_wr = mio_en & rw;
  end
endmodule

// File: rtl/mio_addr_decode.sv
module mio_addr_decode #(
  parameter mio_pkg::addr_t MEM_LIMIT = 16'hFE00
) (
  input  mio_pkg::addr_t addr,
  output logic           in_mem
);
  always_comb begin
    in_mem = (addr < MEM_LIMIT);
  end
endmodule

// File: rtl/mio_mem_model.sv
module mio_mem_model #(
  parameter int MEM_AW = 8,
  parameter int LAT    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                rw,
  input  logic [MEM_AW-1:0]   idx,
  input  mio_pkg::word_t      wdata,
  output mio_pkg::word_t      rdata,
  output logic                mem_ready
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int CW    = $clog2(LAT + 2);
  localparam logic [CW-1:0] LAT_C = CW'(LAT);

  logic [CW-1:0]  cnt_q, cnt_d;
  mio_pkg::word_t store_q [DEPTH];
  logic           wr_fire;

  // latency counter: next state
  always_comb begin
    cnt_d = cnt_q;
    if (!en)
      cnt_d = '0;
    else if (cnt_q != LAT_C)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign mem_ready = en && (cnt_q == LAT_C);
  assign wr_fire   = mem_ready && rw;

  // storage: cleared at reset, written once the access is complete
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store_q[i] <= '0;
    end else if (wr_fire) begin
      store_q[idx] <= wdata;
    end
  end

  assign rdata = store_q[idx];

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAT_C);

  // R5
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mem_ready) |=> (!en || mem_ready));
endmodule

// File: rtl/mio_bus_ctrl.sv
module mio_bus_ctrl #(
  parameter mio_pkg::addr_t MEM_LIMIT = 16'hFE00,
  parameter int             MEM_AW    = 8,
  parameter int             LAT       = 2,
  parameter int             N_IO      = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mio_en,
  input  logic                 rw,
  input  logic [15:0]          addr,
  input  logic [15:0]          wr_data,
  input  logic [N_IO-1:0]      io_ready,
  output logic                 bus_rd,
  output logic                 bus_wr,
  output logic                 mem_sel,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [15:0]          rd_data,
  output logic                 ready
);
  mio_pkg::word_t mem_rdata;
  logic           mem_rdy;

  mio_strobe_gen u_strobe (
    .mio_en (mio_en),
    .rw     (rw),
    .bus_rd (bus_rd),
    .bus_wr (bus_wr)
  );

  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  mio_addr_decode #(.MEM_LIMIT(MEM_LIMIT)) u_dec (
    .addr   (addr),
    .in_mem (mem_sel)
  );

  always_comb begin
    mem_rd = bus_rd & mem_sel;
    mem_wr = bus_wr & mem_sel;
  end

  // R3
  mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (mem_sel && mio_en));

  mio_mem_model #(.MEM_AW(MEM_AW), .LAT(LAT)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (mem_rd | mem_wr),
    .rw        (rw),
    .idx       (addr[MEM_AW-1:0]),
    .wdata     (wr_data),
    .rdata     (mem_rdata),
    .mem_ready (mem_rdy)
  );

  // data path toward the controller: masked outside a memory read
  assign rd_data = mem_rd ? mem_rdata : '0;

  // R4
  data_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd |-> (rd_data == '0));

  assign ready = mem_rdy | (|io_ready);

  // R6
  ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd && !mem_wr && (io_ready == '0)) |-> !ready);
endmodule

// File: tb/mio_bus_ctrl_bench.sv
`timescale 1ns/1ps
module mio_bus_ctrl_bench;
  localparam int LAT    = 2;
  localparam int MEM_AW = 4;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int N_IO   = 2;
  localparam logic [15:0] LIMIT = 16'hFE00;

  logic clk = 0, rst_n = 0;
  logic mio_en = 0, rw = 0;
  logic [15:0] addr = '0, wr_data = '0;
  logic [N_IO-1:0] io_ready = '0;
  logic bus_rd, bus_wr, mem_sel, mem_rd, mem_wr, ready;
  logic [15:0] rd_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] model [DEPTH];

  always #10 clk = ~clk;

  mio_bus_ctrl #(.MEM_LIMIT(LIMIT), .MEM_AW(MEM_AW), .LAT(LAT), .N_IO(N_IO)) u_mio_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .mio_en(mio_en), .rw(rw), .addr(addr),
    .wr_data(wr_data), .io_ready(io_ready), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .mem_sel(mem_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .rd_data(rd_data),
    .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d, input int edges);
    @(negedge clk);
    addr = a; wr_data = d; rw = 1; mio_en = 1;
    repeat (edges) @(posedge clk);
    @(negedge clk);
    mio_en = 0; rw = 0;
  endtask

  task automatic do_read(input logic [15:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    addr = a; rw = 0; mio_en = 1;
    repeat (LAT) @(posedge clk);
    @(negedge clk);
    chk(ready === 1'b1, "R5", {15'd0, ready}, 16'h1);
    chk(rd_data === exp, req, rd_data, exp);
    mio_en = 0;
    #1;
    chk(rd_data === 16'h0, "R4", rd_data, 16'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R8 reset state
    chk(ready === 1'b0, "R8", {15'd0, ready}, 16'h0);
    chk(rd_data === 16'h0, "R8", rd_data, 16'h0);

    // R1 R2 R3: combinational sweep of enable, direction and address
    for (int e = 0; e < 2; e++)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 260; k++) begin
          logic [15:0] a;
          logic exp_sel;
          if (k < 256) a = 16'(k * 256 + (k % 7));
          else a = LIMIT + 16'(k - 258);
          mio_en = e[0]; rw = w[0]; addr = a;
          #1;
          exp_sel = (a < LIMIT);
          chk(bus_rd === (e[0] & ~w[0]), "R1", {15'd0, bus_rd}, {15'd0, e[0] & ~w[0]});
          chk(bus_wr === (e[0] & w[0]), "R1", {15'd0, bus_wr}, {15'd0, e[0] & w[0]});
          chk(mem_sel === exp_sel, "R2", a, {15'd0, exp_sel});
          chk(mem_rd === (e[0] & ~w[0] & exp_sel), "R3", {15'd0, mem_rd}, 16'h0);
          chk(mem_wr === (e[0] & w[0] & exp_sel), "R3", {15'd0, mem_wr}, 16'h0);
        end
    mio_en = 0; rw = 0;

    // R8 all words zero after reset
    for (int i = 0; i < DEPTH; i++) do_read(16'(i), 16'h0, "R8");

    // R5 latency edge by edge
    @(negedge clk); addr = 16'h0001; rw = 0; mio_en = 1; #1;
    chk(ready === 1'b0, "R5", {15'd0, ready}, 16'h0);
    for (int c = 1; c <= LAT + 2; c++) begin
      @(posedge clk); @(negedge clk);
      chk(ready === (c >= LAT), "R5", {15'd0, ready}, {15'd0, c >= LAT});
    end
    mio_en = 0; #1;
    chk(ready === 1'b0, "R5", {15'd0, ready}, 16'h0);

    // R7 fill every word, then read back
    for (int i = 0; i < DEPTH; i++) begin
      logic [15:0] v;
      v = 16'h5A3C ^ 16'(i * 16'h1111);
      do_write(16'(i), v, LAT + 1);
      model[i] = v;
    end
    for (int i = 0; i < DEPTH; i++) do_read(16'(i), model[i], "R7");

    // R7 alias through upper address bits
    do_write(16'h1233, 16'hBEEF, LAT + 1); model[3] = 16'hBEEF;
    do_read(16'h0003, model[3], "R7");
    do_read(16'h4C03, model[3], "R7");

    // R9 write to IO range aliasing onto word 5: no ready, no change
    @(negedge clk); addr = 16'hFE05; wr_data = 16'hDEAD; rw = 1; mio_en = 1;
    repeat (LAT + 2) @(posedge clk);
    @(negedge clk);
    chk(ready === 1'b0, "R9", {15'd0, ready}, 16'h0);
    // R6 IO ready passes through
    io_ready = 2'b10; #1;
    chk(ready === 1'b1, "R6", {15'd0, ready}, 16'h1);
    io_ready = 2'b01; #1;
    chk(ready === 1'b1, "R6", {15'd0, ready}, 16'h1);
    io_ready = 2'b00; mio_en = 0; rw = 0; #1;
    chk(ready === 1'b0, "R6", {15'd0, ready}, 16'h0);
    do_read(16'h0005, model[5], "R9");

    // R10 write withdrawn one edge before ready
    do_write(16'h0007, 16'h1234, LAT - 1);
    do_read(16'h0007, model[7], "R10");
    // write held exactly until ready then dropped before the storing edge
    do_write(16'h0008, 16'h4321, LAT);
    do_read(16'h0008, model[8], "R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule